// File: doc/BRIEF.md
# Routing Register Read-Back Scan Chain

This block gives a diagnostic view of the routing state of a large crosspoint switch. Every output slot holds a 7-bit active select word. The block keeps a parallel-load shift register that spans all 69 slots, 483 bits in all. When serial programming mode is on and the scan pin is low, one rising edge of the serial clock copies every active word into the chain in a single step. With the scan pin raised, each later rising edge moves the chain forward by one bit toward the serial data output. The highest slot is read out first and slot 0 last. Within each word the most significant bit comes out first.

The serial data output pin is also used by the command path. While serial mode and scan are both asserted, the pin carries the end of the read-back chain. At all other times it carries the bit delivered by the command delay path. Capturing and shifting use a private copy of the words, so live routing never changes during a read-back. Once the last of the 483 bits has left the chain, it delivers zeros until the next capture. When serial mode is off, serial clock edges leave the chain untouched.

Top module: `cfg_readback_chain`

## Requirements
- R1: While reset is low the chain is cleared, so a read-back taken after reset and before any capture yields only zeros.
- R2: The chain holds NUM_SLOTS (69) words of WORD_W (7) bits, 483 bits in total. Slot i is taken from `active_words[i*7 +: 7]`, and the 483rd bit shifted out is bit 0 of slot 0.
- R3: A rising `sclk` edge with `serial_mode`=1 and `scan_en`=0 loads every slot of the chain from `active_words` at once, replacing any partly read contents.
- R4: A rising `sclk` edge with `serial_mode`=1 and `scan_en`=1 advances the chain by one bit. Whole words come out in descending slot order, from slot 68 down to slot 0.
- R5: Within each word, bit 6 comes out first and bit 0 last.
- R6: With `serial_mode`=0, `sclk` edges neither capture nor shift. A read-back that was interrupted resumes at the same bit once serial mode returns.
- R7: `sdout` equals the chain's last bit while `serial_mode`=1 and `scan_en`=1, and equals `cmd_sdo` at all other times.
- R8: After 483 shifts following a capture, every further shift delivers 0 until the next capture.
- R9: Changes on `active_words` after the capture edge have no effect on the bits being read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| serial_mode | input | 1 | 1 selects serial programming mode; 0 is parallel mode |
| scan_en | input | 1 | Scan pin: 0 with serial mode captures, 1 shifts out |
| active_words | input | 483 | Active select words, slot i in bits [i*7 +: 7] |
| cmd_sdo | input | 1 | Output bit of the command delay path |
| sdout | output | 1 | Shared serial data output |

## Verification
If a slot register held a wrong bit or was wired to the wrong neighbour, the fault would reach `sdout` during the shift that brings that bit to the end of the chain. That is at most 483 shifts after the capture, and the bit's position in the stream points to the slot and the bit at fault. If the capture or the hold went wrong, the very next scan bit would already differ. The case of a frozen chain in parallel mode only shows up after serial mode returns, as a skipped or repeated bit. A fault in the output select shows on the same cycle as a mismatch against `cmd_sdo`.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2
  } scan_op_e;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic     serial_mode,
  input  logic     scan_en,
  output scan_op_e op
);
  always_comb begin
    if (!serial_mode) begin
      op = OP_HOLD;
    end else if (scan_en) begin
      op = OP_SHIFT;
    end else begin
      op = OP_CAPTURE;
    end
  end
endmodule

// File: rtl/scan_slice.sv
module scan_slice
  import scan_pkg::*;
#(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scan_op_e          op,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_in,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] word_d;
  logic              word_en;

  always_comb begin
    word_en = 1'b0;
    word_d  = word_q;
    case (op)
      OP_CAPTURE: begin
        word_en = 1'b1;
        word_d  = load_word;
      end
      OP_SHIFT: begin
        word_en = 1'b1;
        word_d  = {word_q[WORD_W-2:0], shift_in};
      end
      default: begin
        word_en = 1'b0;
        word_d  = word_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/cfg_readback_chain.sv
module cfg_readback_chain
  import scan_pkg::*;
#(
  parameter int NUM_SLOTS = 69,
  parameter int WORD_W    = 7,
  parameter int SYNC_LEN  = 2,
  localparam int TOTAL    = NUM_SLOTS * WORD_W
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             serial_mode,
  input  logic             scan_en,
  input  logic [TOTAL-1:0] active_words,
  input  logic             cmd_sdo,
  output logic             sdout
);
  logic             rst_q_n;
  scan_op_e         op;
  logic [TOTAL-1:0] chain_q;
  logic             scan_sel;

  scan_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk     (sclk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  scan_ctrl u_ctrl (
    .serial_mode (serial_mode),
    .scan_en     (scan_en),
    .op          (op)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic shift_in;
    if (i == 0) begin : g_tail
      assign shift_in = 1'b0;
    end else begin : g_link
      assign shift_in = chain_q[i*WORD_W-1];
    end

    scan_slice #(.WORD_W(WORD_W)) u_slice (
      .clk       (sclk),
      .rst_n     (rst_q_n),
      .op        (op),
      .load_word (active_words[i*WORD_W +: WORD_W]),
      .shift_in  (shift_in),
      .word_q    (chain_q[i*WORD_W +: WORD_W])
    );
  end

  assign scan_sel = serial_mode & scan_en;

  always_comb begin
    if (scan_sel) begin
      sdout = chain_q[TOTAL-1];
    end else begin
      sdout = cmd_sdo;
    end
  end
endmodule

// File: rtl/cfg_readback_chain_chk.sv
module cfg_readback_chain_chk #(
  parameter int TOTAL = 483
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             serial_mode,
  input logic             scan_en,
  input logic [TOTAL-1:0] active_words,
  input logic [TOTAL-1:0] chain,
  input logic             cmd_sdo,
  input logic             sdout
);
  // R3 and R9: the chain is an exact copy of the words seen at the capture edge
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_q_n)
    (serial_mode && !scan_en) |=> (chain == $past(active_words)));

  // R4: each shift moves every bit one place toward the output
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_q_n)
    (serial_mode && scan_en) |=> (chain[TOTAL-1:1] == $past(chain[TOTAL-2:0])));

  // R8: the tail of the chain fills with zeros
  a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_q_n)
    (serial_mode && scan_en) |=> (chain[0] == 1'b0));

  // R6: parallel mode leaves the chain untouched
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!serial_mode) |=> $stable(chain));

  // R7: shared pin source selection
  a_r7_scan_out: assert property (@(posedge clk) disable iff (!rst_q_n)
    (serial_mode && scan_en) |-> (sdout == chain[TOTAL-1]));

  a_r7_cmd_out: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(serial_mode && scan_en) |-> (sdout == cmd_sdo));
endmodule

bind cfg_readback_chain cfg_readback_chain_chk #(.TOTAL(TOTAL)) u_chk (
  .clk          (sclk),
  .rst_q_n      (rst_q_n),
  .serial_mode  (serial_mode),
  .scan_en      (scan_en),
  .active_words (active_words),
  .chain        (chain_q),
  .cmd_sdo      (cmd_sdo),
  .sdout        (sdout)
);

// File: tb/test_cfg_readback_chain.sv
module test_cfg_readback_chain;
  localparam int NS    = 69;
  localparam int WW    = 7;
  localparam int TOTAL = NS * WW;

  logic             sclk;
  logic             rst_n;
  logic             serial_mode;
  logic             scan_en;
  logic [TOTAL-1:0] active_words;
  logic             cmd_sdo;
  logic             sdout;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit model_q[$];

  cfg_readback_chain i_cfg_readback_chain (
    .sclk         (sclk),
    .rst_n        (rst_n),
    .serial_mode  (serial_mode),
    .scan_en      (scan_en),
    .active_words (active_words),
    .cmd_sdo      (cmd_sdo),
    .sdout        (sdout)
  );

  initial sclk = 1'b0;
  always #2 sclk = ~sclk;

  always @(posedge sclk) cycles++;

  initial begin
    wait (cycles >= 20000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  function automatic logic [WW-1:0] pat(input int p, input int i);
    case (p)
      0: pat = WW'(i);
      1: pat = WW'((i * 37 + 5) ^ (i >> 2));
      default: pat = ~WW'(i * 3);
    endcase
  endfunction

  function automatic bit exp_bit(input int p, input int k);
    logic [WW-1:0] w;
    w = pat(p, NS - 1 - k / WW);
    exp_bit = w[WW - 1 - k % WW];
  endfunction

  task automatic set_words(input int p);
    for (int i = 0; i < NS; i++) active_words[i*WW +: WW] = pat(p, i);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive inputs, compare with model before the edge, then advance model
  task automatic step(input logic s, input logic sc, output logic obs);
    logic expv;
    serial_mode = s;
    scan_en     = sc;
    cmd_sdo     = $urandom_range(1, 0) == 1;
    #1;
    obs  = sdout;
    expv = (s && sc) ? model_q[0] : cmd_sdo;
    check((s && sc) ? "R4 model" : "R7 model", obs, expv);
    @(posedge sclk);
    if (s && !sc) begin
      model_q.delete();
      for (int k = 0; k < TOTAL; k++) begin
        logic [WW-1:0] w;
        w = active_words[(NS - 1 - k / WW)*WW +: WW];
        model_q.push_back(w[WW - 1 - k % WW]);
      end
    end else if (s && sc) begin
      void'(model_q.pop_front());
      model_q.push_back(1'b0);
    end
    @(negedge sclk);
  endtask

  task automatic read_bits(input int p, input int from, input int upto, input string req);
    logic o;
    for (int k = from; k < upto; k++) begin
      step(1'b1, 1'b1, o);
      if (k == TOTAL - 1) check("R2 last bit is slot0 bit0", o, exp_bit(p, k));
      else if (k % WW == 0) check({req, " R4 word order"}, o, exp_bit(p, k));
      else check({req, " R5 msb first"}, o, exp_bit(p, k));
    end
  endtask

  initial begin
    logic o;
    rst_n        = 1'b0;
    serial_mode  = 1'b0;
    scan_en      = 1'b0;
    cmd_sdo      = 1'b0;
    active_words = '0;
    for (int k = 0; k < TOTAL; k++) model_q.push_back(1'b0);
    repeat (4) @(negedge sclk);
    rst_n = 1'b1;
    repeat (4) @(negedge sclk);

    // R1: chain empty after reset
    set_words(0);
    for (int k = 0; k < 10; k++) begin
      step(1'b1, 1'b1, o);
      check("R1 reset zeros", o, 1'b0);
    end

    // R3: capture pattern 0, cmd path visible on the capture cycle (R7)
    step(1'b1, 1'b0, o);
    check("R7 cmd during capture", o, cmd_sdo);
    read_bits(0, 0, TOTAL, "R3");
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b1, o);
      check("R8 zero fill", o, 1'b0);
    end

    // R9: change words after capture; R6: pause in parallel mode
    set_words(1);
    step(1'b1, 1'b0, o);
    set_words(2);
    read_bits(1, 0, 100, "R9");
    for (int k = 0; k < 20; k++) begin
      step(1'b0, (k % 2) == 1, o);
      check("R7 parallel mode shows cmd", o, cmd_sdo);
    end
    read_bits(1, 100, TOTAL, "R6 resume");
    step(1'b1, 1'b1, o);
    check("R8 after full read", o, 1'b0);

    // R6: parallel mode never captures
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int k = 0; k < 14; k++) begin
      step(1'b1, 1'b1, o);
      check("R6 no capture in parallel", o, 1'b0);
    end

    // R3: recapture in the middle of a read
    step(1'b1, 1'b0, o);
    read_bits(2, 0, 50, "R3 partial");
    set_words(0);
    step(1'b1, 1'b0, o);
    read_bits(0, 0, TOTAL, "R3 recapture");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule